// File: doc/BRIEF.md
# Black-Level Offset Calibration Sequencer

This block is the digital side of an imaging front end's black-level correction loop. It divides the master clock down to a conversion clock, using a ratio of two or three. After a hardware reset it waits through a settling phase. It then runs a timed offset calibration, and after that it holds the learned result for normal operation.

During calibration, a signed digital error sample stands in for the analog chain. Once per conversion clock, the block nudges a signed offset-cancel word up or down by one step. The correction DAC receives the sum of that word and a programmable black clamp target. The sum is registered and limited to the DAC's code range. A done flag tells the rest of the chip when the calibration window is over.

Both phase lengths are counted in conversion clocks. The default calibration length meets the minimum calibration window. The default settling length covers a 2 ms wait at an 18 MHz conversion rate.

Top module: `black_cal_seq`

## Requirements
- R1: The conversion clock has a period of 2 input clocks when `div3_sel_i` is 0 and 3 input clocks when it is 1, measured from the second rising edge after reset onward. It is high for exactly one input clock per period.
- R2: A change of `div3_sel_i` takes effect only at a conversion-clock rising edge. The interval between two rising edges is therefore always exactly 2 or 3 input clocks.
- R3: After reset, a settling phase of `SETTLE_TICKS` conversion clocks is followed by a calibration phase of `CAL_TICKS` conversion clocks. `cal_done_o` goes high at the input-clock edge that produces rising edge number `SETTLE_TICKS + CAL_TICKS`.
- R4: During calibration, the offset word is sampled once per conversion clock. It steps by +1 when `err_i` is positive, by -1 when `err_i` is negative (two's complement), and holds when `err_i` is zero.
- R5: The offset word saturates at -2^(OFS_W-1) and 2^(OFS_W-1)-1 instead of wrapping.
- R6: `err_i` has no effect on the offset word during settling or after done.
- R7: Once high, `cal_done_o` stays high until the next reset.
- R8: The clamp target is limited to the range 14 to 76. Values below 14 act as 14, and values above 76 act as 76.
- R9: `dac_code_o` equals the limited clamp target plus the signed offset word, saturated to the range 0 to 2^DAC_W-1. It is registered, so it follows its inputs one input clock later.
- R10: While `rst_ni` is low, `conv_clk_o`, `cal_done_o` and `dac_code_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div3_sel_i | input | 1 | Divide select: 0 divides by two, 1 divides by three |
| clamp_tgt_i | input | CLAMP_W | Black clamp target in LSB |
| err_i | input | ERR_W | Signed black-level error sample |
| conv_clk_o | output | 1 | Divided conversion clock |
| dac_code_o | output | DAC_W | Correction DAC code |
| cal_done_o | output | 1 | Calibration complete, sticky until reset |

## Verification
The bench drives a nonzero error during settling and compares the DAC code against the plain clamp target at the end of that phase. A design that starts stepping early shows an offset there. It runs each calibration long enough that the offset word must hit both rails, so a wrapping accumulator would land far from the expected code. Clamp targets outside 14..76 and sums past either end of a narrow DAC range expose a missing limiter. Flipping the divide select every few cycles after calibration catches a divider that cuts a period short when the mode changes mid-count.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
  localparam int unsigned CLAMP_LO = 14;
  localparam int unsigned CLAMP_HI = 76;

  typedef enum logic [1:0] {
    PH_SETTLE = 2'd0,
    PH_CAL    = 2'd1,
    PH_DONE   = 2'd2
  } phase_e;
endpackage

// File: rtl/cal_clk_div.sv
module cal_clk_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div3_i,
  output logic conv_clk_o,
  output logic tick_o
);
  logic [1:0] cnt_q;
  logic       mode_q;
  logic       clk_q;
  logic       wrap;

  assign wrap       = (cnt_q == (mode_q ? 2'd2 : 2'd1));
  assign tick_o     = wrap;
  assign conv_clk_o = clk_q;

  // mode is only resampled on wrap, so a period is never cut short
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= 2'd0;
      mode_q <= 1'b0;
      clk_q  <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= 2'd0;
      mode_q <= div3_i;
      clk_q  <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 2'd1;
      clk_q  <= 1'b0;
    end
  end

  a_r1_single_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_clk_o |=> !conv_clk_o);

  a_r2_mode_at_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q) |-> conv_clk_o);
endmodule

// File: rtl/cal_ofs_loop.sv
module cal_ofs_loop
  import cal_seq_pkg::*;
#(
  parameter int unsigned SETTLE_TICKS = 36000,
  parameter int unsigned CAL_TICKS    = 40000,
  parameter int unsigned OFS_W        = 8,
  parameter int unsigned ERR_W        = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic signed [ERR_W-1:0] err_i,
  output logic signed [OFS_W-1:0] ofs_o,
  output logic                    done_o
);
  localparam int unsigned MAX_TICKS = (SETTLE_TICKS > CAL_TICKS) ? SETTLE_TICKS : CAL_TICKS;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_TICKS - 1);
  localparam logic [CNT_W-1:0] CAL_LAST    = CNT_W'(CAL_TICKS - 1);
  localparam logic [OFS_W-1:0] OFS_MAX = {1'b0, {(OFS_W-1){1'b1}}};
  localparam logic [OFS_W-1:0] OFS_MIN = {1'b1, {(OFS_W-1){1'b0}}};
  localparam logic [OFS_W-1:0] OFS_ONE = {{(OFS_W-1){1'b0}}, 1'b1};

  phase_e                  state_q;
  logic [CNT_W-1:0]        cnt_q;
  logic signed [OFS_W-1:0] ofs_q;
  logic [OFS_W-1:0]        ofs_nxt;
  logic                    err_pos, err_neg;

  assign err_neg = err_i[ERR_W-1];
  assign err_pos = !err_i[ERR_W-1] && (err_i != '0);

  always_comb begin
    ofs_nxt = ofs_q;
    if (err_pos && (ofs_q != OFS_MAX))      ofs_nxt = ofs_q + OFS_ONE;
    else if (err_neg && (ofs_q != OFS_MIN)) ofs_nxt = ofs_q - OFS_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_SETTLE;
      cnt_q   <= '0;
      ofs_q   <= '0;
    end else if (tick_i) begin
      case (state_q)
        PH_SETTLE: begin
          if (cnt_q == SETTLE_LAST) begin
            state_q <= PH_CAL;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_CAL: begin
          ofs_q <= ofs_nxt;
          if (cnt_q == CAL_LAST) state_q <= PH_DONE;
          else                   cnt_q   <= cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign ofs_o  = ofs_q;
  assign done_o = (state_q == PH_DONE);

  a_r7_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  a_r6_ofs_moves_in_cal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ofs_q != $past(ofs_q)) |-> $past(state_q == PH_CAL && tick_i));
endmodule

// File: rtl/cal_code_sum.sv
module cal_code_sum
  import cal_seq_pkg::*;
#(
  parameter int unsigned CLAMP_W = 7,
  parameter int unsigned OFS_W   = 8,
  parameter int unsigned DAC_W   = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CLAMP_W-1:0]      clamp_i,
  input  logic signed [OFS_W-1:0] ofs_i,
  output logic [DAC_W-1:0]        dac_o
);
  localparam int unsigned W1    = (CLAMP_W > OFS_W) ? CLAMP_W : OFS_W;
  localparam int unsigned SUM_W = ((W1 > DAC_W) ? W1 : DAC_W) + 2;
  localparam logic signed [SUM_W-1:0] DAC_MAX_S = SUM_W'((1 << DAC_W) - 1);

  logic [CLAMP_W-1:0]      clamp_lim;
  logic signed [SUM_W-1:0] sum_s;
  logic [DAC_W-1:0]        code_d;
  logic [DAC_W-1:0]        dac_q;

  always_comb begin
    if (clamp_i < CLAMP_W'(CLAMP_LO))      clamp_lim = CLAMP_W'(CLAMP_LO);
    else if (clamp_i > CLAMP_W'(CLAMP_HI)) clamp_lim = CLAMP_W'(CLAMP_HI);
    else                                   clamp_lim = clamp_i;
  end

  assign sum_s = $signed({{(SUM_W-CLAMP_W){1'b0}}, clamp_lim})
               + $signed({{(SUM_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i});

  always_comb begin
    if (sum_s[SUM_W-1])         code_d = '0;
    else if (sum_s > DAC_MAX_S) code_d = '1;
    else                        code_d = sum_s[DAC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dac_q <= '0;
    else         dac_q <= code_d;
  end

  assign dac_o = dac_q;

  // clamp floor is 14, so a zero code needs a negative offset
  a_r9_zero_needs_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && dac_o == '0) |-> ($past(ofs_i) < 0));
endmodule

// File: rtl/black_cal_seq.sv
module black_cal_seq #(
  parameter int unsigned DAC_W        = 8,
  parameter int unsigned OFS_W        = 8,
  parameter int unsigned ERR_W        = 6,
  parameter int unsigned CLAMP_W      = 7,
  parameter int unsigned SETTLE_TICKS = 36000,
  parameter int unsigned CAL_TICKS    = 40000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    div3_sel_i,
  input  logic [CLAMP_W-1:0]      clamp_tgt_i,
  input  logic signed [ERR_W-1:0] err_i,
  output logic                    conv_clk_o,
  output logic [DAC_W-1:0]        dac_code_o,
  output logic                    cal_done_o
);
  logic                    tick;
  logic signed [OFS_W-1:0] ofs;

  cal_clk_div u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div3_i     (div3_sel_i),
    .conv_clk_o (conv_clk_o),
    .tick_o     (tick)
  );

  cal_ofs_loop #(
    .SETTLE_TICKS (SETTLE_TICKS),
    .CAL_TICKS    (CAL_TICKS),
    .OFS_W        (OFS_W),
    .ERR_W        (ERR_W)
  ) u_loop (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .err_i  (err_i),
    .ofs_o  (ofs),
    .done_o (cal_done_o)
  );

  cal_code_sum #(
    .CLAMP_W (CLAMP_W),
    .OFS_W   (OFS_W),
    .DAC_W   (DAC_W)
  ) u_sum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clamp_i (clamp_tgt_i),
    .ofs_i   (ofs),
    .dac_o   (dac_code_o)
  );
endmodule

// File: tb/black_cal_seq_bench.sv
module black_cal_seq_bench;
  localparam int DAC_W = 6, OFS_W = 5, ERR_W = 6, CLAMP_W = 7;
  localparam int SETTLE = 4, CAL = 24;

  typedef struct packed {
    logic              mode;
    logic [6:0]        clamp;
    logic signed [7:0] err;
    logic [7:0]        exp_settle;
    logic [7:0]        exp_final;
  } vec_t;

  // offset rails are -16..15, DAC range 0..63
  localparam vec_t VECS [8] = '{
    '{1'b0, 7'd40,  8'sd5,  8'd40, 8'd55},
    '{1'b1, 7'd14, -8'sd5,  8'd14, 8'd0 },
    '{1'b0, 7'd76,  8'sd0,  8'd63, 8'd63},
    '{1'b1, 7'd5,   8'sd0,  8'd14, 8'd14},
    '{1'b0, 7'd100, 8'sd5,  8'd63, 8'd63},
    '{1'b1, 7'd30, -8'sd5,  8'd30, 8'd14},
    '{1'b1, 7'd20,  8'sd5,  8'd20, 8'd35},
    '{1'b0, 7'd90, -8'sd5,  8'd63, 8'd60}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic div3 = 1'b0;
  logic [CLAMP_W-1:0] clamp = '0;
  logic signed [ERR_W-1:0] err = '0;
  logic conv_clk, done;
  logic [DAC_W-1:0] dac;

  int n_chk = 0, n_fail = 0, cycles = 0;

  always #5 clk = ~clk;

  black_cal_seq #(
    .DAC_W(DAC_W), .OFS_W(OFS_W), .ERR_W(ERR_W), .CLAMP_W(CLAMP_W),
    .SETTLE_TICKS(SETTLE), .CAL_TICKS(CAL)
  ) u_black_cal_seq (
    .clk_i(clk), .rst_ni(rst_n), .div3_sel_i(div3), .clamp_tgt_i(clamp),
    .err_i(err), .conv_clk_o(conv_clk), .dac_code_o(dac), .cal_done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic run_vec(input vec_t v);
    int rises = 0, last_rise = 0, cyc = 0, bad = 0, per;
    bit prev_hi = 0, seen = 0;
    logic [DAC_W-1:0] hold;
    per = v.mode ? 3 : 2;
    div3 = v.mode; clamp = v.clamp; err = ERR_W'(v.err); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!conv_clk && !done && dac == 0, "R10 reset state", {conv_clk, done, dac}, 0);
    rst_n = 1'b1;
    while (!seen && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (conv_clk) begin
        if (prev_hi) bad++;
        rises++;
        if (rises >= 2 && cyc - last_rise != per) bad++;
        last_rise = cyc;
        if (rises == SETTLE)
          chk(dac == v.exp_settle, "R6 R8 settle code", dac, v.exp_settle);
      end
      prev_hi = conv_clk;
      if (done) begin
        seen = 1;
        chk(rises == SETTLE + CAL, "R3 done timing", rises, SETTLE + CAL);
      end
    end
    if (!seen) chk(0, "R3 done never rose", 0, 1);
    chk(bad == 0, "R1 period/width", bad, 0);
    repeat (3) @(negedge clk);
    chk(dac == v.exp_final, "R4 R5 R9 final code", dac, v.exp_final);
    hold = dac;
    err = (v.err >= 0) ? -6'sd5 : 6'sd5;
    repeat (12) @(negedge clk);
    chk(dac == hold && done, "R6 R7 hold after done", {done, dac}, {1'b1, hold});
  endtask

  initial begin
    int bad, last, rises, a, b;
    bit prev;
    for (int i = 0; i < 8; i++) run_vec(VECS[i]);

    // R2: select toggles at odd moments, no short period allowed
    bad = 0; last = 0; rises = 0; prev = 0;
    for (int c = 1; c <= 240; c++) begin
      @(negedge clk);
      if (c % 7 == 0) div3 = ~div3;
      if (conv_clk) begin
        if (prev) bad++;
        rises++;
        if (rises >= 2 && c - last != 2 && c - last != 3) bad++;
        last = c;
      end
      prev = conv_clk;
    end
    chk(bad == 0, "R2 glitch-free switch", bad, 0);

    for (int m = 0; m < 2; m++) begin
      div3 = (m == 0);
      repeat (8) @(negedge clk);
      a = 0; b = 0;
      for (int c = 1; c <= 20 && b == 0; c++) begin
        @(negedge clk);
        if (conv_clk) begin
          if (a == 0) a = c; else b = c;
        end
      end
      chk(b - a == (m == 0 ? 3 : 2), "R1 settled period", b - a, (m == 0 ? 3 : 2));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule